// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block sits in the front end of a simultaneous multithreading core. On every cycle it decides which hardware threads get a fetch slot and how many instructions each granted thread may bring in. The total fetch width is fixed. A split setting divides that width over one, two or four fetch ports. A policy setting picks how the threads are ranked: plain rotation, or one of four live pipeline-occupancy counters.

For each thread the block keeps four saturating counters: instructions in flight in the decode and queue stages, unresolved branches, outstanding data-cache misses, and the queue position of the thread's oldest instruction. Each counter has its own increment and decrement strobe, driven by the surrounding pipeline. Per-thread ready and stall inputs remove threads from consideration. Threads with equal counter values are ordered by a rotating pointer. For each fetch port the result is registered as a one-hot thread grant and a budget.

Top module: `fetch_thread_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every grant and budget output is zero, every counter is zero and the rotation pointer is at thread 0. The first rotation grant therefore goes to thread 0.
- R2: Each counter is 6 bits wide and saturates. An increment at 63 leaves it at 63, and a decrement at 0 leaves it at 0.
- R3: When a counter's increment and decrement strobes are high in the same cycle, the counter keeps its value.
- R4: A thread is granted only if its ready bit was 1 and its stall bit was 0 in the cycle before the grant. A port with no eligible thread left for it shows an all-zero grant and a budget of 0.
- R5: split_i selects the port layout: 0 = one port with budget 8, 1 = two ports with budget 4 each, 2 = four ports with budget 2 each, 3 = two ports (see R6). Ports beyond the selected count never grant, no thread is granted on two ports, and in codes 0 to 2 the budget ignores avail_i.
- R6: With split_i = 3, port 0 gets min(avail of its thread, 8). Port 1 gets min(avail of its thread, 8 minus the port 0 budget), which may be 0 while port 1 still grants. The two budgets never sum to more than 8.
- R7: policy_i = 0 is rotation. Port k grants the k-th eligible thread counting upward (with wrap) from the pointer. The pointer advances by one after every cycle that grants anything. This same distance from the pointer breaks ties under every other policy.
- R8: policy_i = 1 ranks threads by the in-flight instruction counter, lowest first, and port 0 takes the best thread.
- R9: policy_i = 2 ranks threads by the unresolved-branch counter, lowest first.
- R10: policy_i = 3 ranks threads by the outstanding-miss counter, lowest first.
- R11: policy_i = 4 ranks threads by the oldest-instruction queue position, highest first.
- R12: Grant and budget outputs are registered. A change on ready, stall, policy, split or avail shows after one rising edge. A counter strobe shows after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 3 | Ranking policy code (R7 to R11) |
| split_i | input | 2 | Port layout code (R5, R6) |
| ready_i | input | 8 | Per-thread ready |
| stall_i | input | 8 | Per-thread stall |
| avail_i | input | 32 | Per-thread supply count, thread t at bits [4t+3:4t] |
| infl_inc_i | input | 8 | In-flight counter increment strobes |
| infl_dec_i | input | 8 | In-flight counter decrement strobes |
| br_inc_i | input | 8 | Branch counter increment strobes |
| br_dec_i | input | 8 | Branch counter decrement strobes |
| miss_inc_i | input | 8 | Miss counter increment strobes |
| miss_dec_i | input | 8 | Miss counter decrement strobes |
| qpos_inc_i | input | 8 | Queue position counter increment strobes |
| qpos_dec_i | input | 8 | Queue position counter decrement strobes |
| grant_o | output | 32 | One-hot grant, port p at bits [8p+7:8p], bit t = thread t |
| budget_o | output | 16 | Budget, port p at bits [4p+3:4p] |

## Verification
The assertions assume only that every input carries a known value at each rising edge after reset. Any strobe pattern is legal, including both strobes together or a strobe on a saturated counter, and any ready, stall, avail or code combination is legal too. The bench drives all inputs on the falling edge and holds them for whole cycles. It starts every scenario from reset, so counter values and the pointer position are known. It chooses counter values that differ wherever an order is checked, so that no expected result depends on a tie whose pointer position the bench does not track.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    POL_ROUND    = 3'd0,
    POL_INFLIGHT = 3'd1,
    POL_BRANCH   = 3'd2,
    POL_DMISS    = 3'd3,
    POL_QAGE     = 3'd4
  } policy_e;

  typedef enum logic [1:0] {
    SPLIT_1X8 = 2'd0,
    SPLIT_2X4 = 2'd1,
    SPLIT_4X2 = 2'd2,
    SPLIT_2X8 = 2'd3
  } split_e;

  localparam int NUM_KINDS = 4;
  localparam int K_INFL    = 0;
  localparam int K_BR      = 1;
  localparam int K_MISS    = 2;
  localparam int K_QPOS    = 3;
endpackage

// File: rtl/fts_sat_ctr.sv
module fts_sat_ctr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc_i && !dec_i && (cnt_q != '1)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + W'(1);
    end else if (dec_i && !inc_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && inc_i && !dec_i) |=> (cnt_q == '1));
  a_r2_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec_i && !inc_i) |=> (cnt_q == '0));
  a_r3_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i) |=> $stable(cnt_q));
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fts_rank.sv
module fts_rank #(
  parameter int NUM_THR = 8,
  parameter int KEY_W   = 6,
  parameter int TID_W   = $clog2(NUM_THR)
) (
  input  logic [NUM_THR*KEY_W-1:0] key_i,
  input  logic [NUM_THR-1:0]       elig_i,
  input  logic [TID_W-1:0]         ptr_i,
  output logic [NUM_THR*TID_W-1:0] rank_o
);
  // Composite order: key first, then rotated distance from the pointer.
  // Distances are unique, so eligible threads get distinct ranks.
  logic [KEY_W+TID_W-1:0] comp [NUM_THR];

  always_comb begin
    for (int t = 0; t < NUM_THR; t++) begin
      comp[t] = {key_i[t*KEY_W +: KEY_W], TID_W'(TID_W'(t) - ptr_i)};
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_THR; t++) begin
      int ahead;
      ahead = 0;
      for (int u = 0; u < NUM_THR; u++) begin
        if (u != t && elig_i[u] && (comp[u] < comp[t])) ahead++;
      end
      rank_o[t*TID_W +: TID_W] = TID_W'(ahead);
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fts_pkg::*;
#(
  parameter int NUM_THR = 8,
  parameter int CNT_W   = 6,
  parameter int FETCH_W = 8,
  parameter int AVAIL_W = 4,
  parameter int NUM_PORT = 4,
  parameter int BUD_W   = $clog2(FETCH_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  policy_i,
  input  logic [1:0]                  split_i,
  input  logic [NUM_THR-1:0]          ready_i,
  input  logic [NUM_THR-1:0]          stall_i,
  input  logic [NUM_THR*AVAIL_W-1:0]  avail_i,
  input  logic [NUM_THR-1:0]          infl_inc_i,
  input  logic [NUM_THR-1:0]          infl_dec_i,
  input  logic [NUM_THR-1:0]          br_inc_i,
  input  logic [NUM_THR-1:0]          br_dec_i,
  input  logic [NUM_THR-1:0]          miss_inc_i,
  input  logic [NUM_THR-1:0]          miss_dec_i,
  input  logic [NUM_THR-1:0]          qpos_inc_i,
  input  logic [NUM_THR-1:0]          qpos_dec_i,
  output logic [NUM_PORT*NUM_THR-1:0] grant_o,
  output logic [NUM_PORT*BUD_W-1:0]   budget_o
);
  localparam int TID_W = $clog2(NUM_THR);
  localparam int PC_W  = $clog2(NUM_PORT + 1);

  // ---------------- status counters ----------------
  logic [NUM_THR-1:0] inc_k [NUM_KINDS];
  logic [NUM_THR-1:0] dec_k [NUM_KINDS];
  logic [CNT_W-1:0]   cnt   [NUM_KINDS][NUM_THR];

  assign inc_k[K_INFL] = infl_inc_i;
  assign dec_k[K_INFL] = infl_dec_i;
  assign inc_k[K_BR]   = br_inc_i;
  assign dec_k[K_BR]   = br_dec_i;
  assign inc_k[K_MISS] = miss_inc_i;
  assign dec_k[K_MISS] = miss_dec_i;
  assign inc_k[K_QPOS] = qpos_inc_i;
  assign dec_k[K_QPOS] = qpos_dec_i;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      fts_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (inc_k[k][t]),
        .dec_i (dec_k[k][t]),
        .cnt_o (cnt[k][t])
      );
    end
  end

  // ---------------- ranking key per policy ----------------
  logic [NUM_THR*CNT_W-1:0] key_flat;

  always_comb begin
    for (int t = 0; t < NUM_THR; t++) begin
      case (policy_e'(policy_i))
        POL_INFLIGHT: key_flat[t*CNT_W +: CNT_W] = cnt[K_INFL][t];
        POL_BRANCH:   key_flat[t*CNT_W +: CNT_W] = cnt[K_BR][t];
        POL_DMISS:    key_flat[t*CNT_W +: CNT_W] = cnt[K_MISS][t];
        POL_QAGE:     key_flat[t*CNT_W +: CNT_W] = ~cnt[K_QPOS][t];
        default:      key_flat[t*CNT_W +: CNT_W] = '0;
      endcase
    end
  end

  logic [NUM_THR-1:0]       elig;
  logic [TID_W-1:0]         ptr_q, ptr_d;
  logic [NUM_THR*TID_W-1:0] rank_flat;

  assign elig = ready_i & ~stall_i;

  fts_rank #(.NUM_THR(NUM_THR), .KEY_W(CNT_W), .TID_W(TID_W)) u_rank (
    .key_i  (key_flat),
    .elig_i (elig),
    .ptr_i  (ptr_q),
    .rank_o (rank_flat)
  );

  // ---------------- port layout ----------------
  logic [PC_W-1:0]  nport;
  logic [BUD_W-1:0] cap;

  always_comb begin
    case (split_e'(split_i))
      SPLIT_2X4: begin nport = PC_W'(2); cap = BUD_W'(FETCH_W / 2); end
      SPLIT_4X2: begin nport = PC_W'(4); cap = BUD_W'(FETCH_W / 4); end
      SPLIT_2X8: begin nport = PC_W'(2); cap = BUD_W'(FETCH_W);     end
      default:   begin nport = PC_W'(1); cap = BUD_W'(FETCH_W);     end
    endcase
  end

  // ---------------- grant and budget selection ----------------
  logic [NUM_THR-1:0] gsel [NUM_PORT];
  logic [BUD_W-1:0]   bsel [NUM_PORT];
  logic               any_grant;

  always_comb begin
    for (int p = 0; p < NUM_PORT; p++) begin
      for (int t = 0; t < NUM_THR; t++) begin
        gsel[p][t] = elig[t] && (rank_flat[t*TID_W +: TID_W] == TID_W'(p))
                     && (PC_W'(p) < nport);
      end
    end
  end

  always_comb begin
    int sup0, sup1, b0, b1;
    sup0 = 0;
    sup1 = 0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (gsel[0][t]) sup0 = int'(avail_i[t*AVAIL_W +: AVAIL_W]);
      if (gsel[1][t]) sup1 = int'(avail_i[t*AVAIL_W +: AVAIL_W]);
    end
    b0 = (sup0 > FETCH_W) ? FETCH_W : sup0;
    b1 = (sup1 > FETCH_W - b0) ? (FETCH_W - b0) : sup1;
    for (int p = 0; p < NUM_PORT; p++) begin
      bsel[p] = (|gsel[p]) ? cap : '0;
    end
    if (split_e'(split_i) == SPLIT_2X8) begin
      bsel[0] = (|gsel[0]) ? BUD_W'(b0) : '0;
      bsel[1] = (|gsel[1]) ? BUD_W'(b1) : '0;
    end
  end

  assign any_grant = |gsel[0];
  assign ptr_d     = ptr_q + TID_W'(1);

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (any_grant) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o  <= '0;
      budget_o <= '0;
    end else begin
      for (int p = 0; p < NUM_PORT; p++) begin
        grant_o[p*NUM_THR +: NUM_THR] <= gsel[p];
        budget_o[p*BUD_W +: BUD_W]    <= bsel[p];
      end
    end
  end

  // ---------------- assertions ----------------
  logic [NUM_PORT-1:0] tcol [NUM_THR];
  int                  bsum;

  always_comb begin
    bsum = 0;
    for (int p = 0; p < NUM_PORT; p++) begin
      bsum += int'(budget_o[p*BUD_W +: BUD_W]);
      for (int t = 0; t < NUM_THR; t++) tcol[t][p] = grant_o[p*NUM_THR + t];
    end
  end

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port_chk
    a_r5_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o[p*NUM_THR +: NUM_THR]));
    a_r5_unused_port: assert property (@(posedge clk) disable iff (!rst_n)
      (PC_W'(p) >= nport) |=> (grant_o[p*NUM_THR +: NUM_THR] == '0));
    a_r4_idle_budget: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[p*NUM_THR +: NUM_THR] == '0) |-> (budget_o[p*BUD_W +: BUD_W] == '0));
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr_chk
      a_r4_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[p*NUM_THR + t] |-> $past(ready_i[t] && !stall_i[t]));
    end
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_once_chk
    a_r5_thread_once: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tcol[t]) <= 1);
  end

  a_r6_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bsum <= FETCH_W);
endmodule

// File: tb/fetch_thread_sel_tb.sv
`timescale 1ns/1ps
module fetch_thread_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  pol;
  logic [1:0]  spl;
  logic [7:0]  rdy, stl;
  logic [31:0] avail;
  logic [7:0]  inc_v [4];
  logic [7:0]  dec_v [4];
  logic [31:0] gnt;
  logic [15:0] bud;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  fetch_thread_sel u_dut (
    .clk(clk), .rst_n(rst_n), .policy_i(pol), .split_i(spl),
    .ready_i(rdy), .stall_i(stl), .avail_i(avail),
    .infl_inc_i(inc_v[0]), .infl_dec_i(dec_v[0]),
    .br_inc_i(inc_v[1]),   .br_dec_i(dec_v[1]),
    .miss_inc_i(inc_v[2]), .miss_dec_i(dec_v[2]),
    .qpos_inc_i(inc_v[3]), .qpos_dec_i(dec_v[3]),
    .grant_o(gnt), .budget_o(bud)
  );

  function automatic logic [7:0] pg(input int p);
    return gnt[p*8 +: 8];
  endfunction
  function automatic logic [3:0] pb(input int p);
    return bud[p*4 +: 4];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pol = 3'd0; spl = 2'd0; rdy = 8'h00; stl = 8'h00; avail = 32'h0;
    for (int k = 0; k < 4; k++) begin inc_v[k] = 8'h00; dec_v[k] = 8'h00; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_counts(input int kind, input int tgt [8]);
    int mx;
    mx = 0;
    for (int t = 0; t < 8; t++) if (tgt[t] > mx) mx = tgt[t];
    for (int c = 0; c < mx; c++) begin
      @(negedge clk);
      for (int t = 0; t < 8; t++) inc_v[kind][t] = (c < tgt[t]);
    end
    @(negedge clk);
    inc_v[kind] = 8'h00;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_rotate();
    do_reset();
    chk("R1", "grant in reset", gnt, 32'h0);
    chk("R1", "budget in reset", {16'h0, bud}, 32'h0);
    spl = 2'd0; rdy = 8'hFF;
    @(negedge clk);
    chk("R1", "first rotation grant", pg(0), 8'h01);
    chk("R5", "1x8 budget", pb(0), 4'd8);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R7", "rotation step", pg(0), 8'h01 << (i % 8));
    end
    do_reset();
    spl = 2'd2; rdy = 8'hFF;
    @(negedge clk);
    chk("R7", "4x2 rotation port0", pg(0), 8'h01);
    chk("R7", "4x2 rotation port3", pg(3), 8'h08);
    @(negedge clk);
    chk("R7", "4x2 advance port0", pg(0), 8'h02);
    chk("R7", "4x2 advance port3", pg(3), 8'h10);
  endtask

  task automatic t_eligibility();
    do_reset();
    spl = 2'd2; rdy = 8'h05; stl = 8'h01;
    @(negedge clk);
    chk("R4", "only eligible thread", pg(0), 8'h04);
    chk("R5", "4x2 budget", pb(0), 4'd2);
    chk("R4", "empty ports grant", {8'h0, pg(1), pg(2), pg(3)}, 32'h0);
    chk("R4", "empty ports budget", {20'h0, pb(1), pb(2), pb(3)}, 32'h0);
    stl = 8'h05;
    #1;
    chk("R12", "grant held before edge", pg(0), 8'h04);
    @(negedge clk);
    chk("R4", "stall removes grant", pg(0), 8'h00);
  endtask

  task automatic t_inflight();
    do_reset();
    set_counts(0, '{7, 6, 5, 4, 3, 2, 1, 0});
    pol = 3'd1; spl = 2'd2; rdy = 8'hFF;
    settle();
    chk("R8", "port0", pg(0), 8'h80);
    chk("R8", "port1", pg(1), 8'h40);
    chk("R8", "port2", pg(2), 8'h20);
    chk("R8", "port3", pg(3), 8'h10);
  endtask

  task automatic t_branch();
    do_reset();
    set_counts(1, '{3, 0, 5, 1, 7, 2, 6, 4});
    set_counts(0, '{0, 9, 9, 9, 9, 9, 9, 9});
    pol = 3'd2; spl = 2'd1; rdy = 8'hFF;
    settle();
    chk("R9", "port0", pg(0), 8'h02);
    chk("R9", "port1", pg(1), 8'h08);
    chk("R5", "2x4 budget ignores avail", {pb(0), pb(1)}, 8'h44);
    chk("R5", "2x4 unused ports", {pg(2), pg(3)}, 16'h0);
  endtask

  task automatic t_miss();
    do_reset();
    set_counts(2, '{4, 6, 1, 7, 3, 5, 2, 0});
    pol = 3'd3; spl = 2'd0; rdy = 8'hFF;
    settle();
    chk("R10", "port0", pg(0), 8'h80);
    chk("R5", "1x8 unused ports", {8'h0, pg(1), pg(2), pg(3)}, 32'h0);
  endtask

  task automatic t_qpos();
    do_reset();
    set_counts(3, '{0, 9, 0, 3, 12, 0, 0, 5});
    pol = 3'd4; spl = 2'd2; rdy = 8'hFF;
    settle();
    chk("R11", "ports", {pg(0), pg(1), pg(2), pg(3)}, 32'h10028008);
  endtask

  task automatic t_saturate();
    do_reset();
    set_counts(0, '{70, 62, 0, 0, 0, 0, 0, 0});
    pol = 3'd1; spl = 2'd0; rdy = 8'h03;
    settle();
    chk("R2", "upper saturation", pg(0), 8'h02);
    do_reset();
    @(negedge clk); dec_v[0] = 8'h04;
    repeat (3) @(negedge clk);
    dec_v[0] = 8'h00;
    set_counts(0, '{0, 0, 0, 1, 0, 0, 0, 0});
    pol = 3'd1; spl = 2'd0; rdy = 8'h0C;
    settle();
    chk("R2", "lower saturation", pg(0), 8'h04);
  endtask

  task automatic t_both_strobes();
    do_reset();
    set_counts(0, '{1, 2, 3, 0, 0, 0, 0, 0});
    @(negedge clk); inc_v[0] = 8'h02; dec_v[0] = 8'h02;
    repeat (2) @(negedge clk);
    inc_v[0] = 8'h00; dec_v[0] = 8'h00;
    pol = 3'd1; spl = 2'd2; rdy = 8'h07;
    settle();
    chk("R3", "order after both strobes", {pg(0), pg(1), pg(2), pg(3)}, 32'h01020400);
  endtask

  task automatic t_wide_pair();
    do_reset();
    set_counts(0, '{0, 1, 0, 0, 0, 0, 0, 0});
    pol = 3'd1; spl = 2'd3; rdy = 8'h03; avail = 32'h00000065;
    settle();
    chk("R6", "grants", {pg(0), pg(1)}, 16'h0102);
    chk("R6", "budgets 5+3", {pb(0), pb(1)}, 8'h53);
    chk("R6", "unused ports", {pg(2), pg(3)}, 16'h0);
    avail = 32'h0000006C;
    @(negedge clk);
    chk("R12", "avail change after one edge", {pb(0), pb(1)}, 8'h80);
    chk("R6", "port1 granted with zero budget", pg(1), 8'h02);
    avail = 32'h00000032;
    @(negedge clk);
    chk("R6", "budgets 2+3", {pb(0), pb(1)}, 8'h23);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_rotate();
    t_eligibility();
    t_inflight();
    t_branch();
    t_miss();
    t_qpos();
    t_saturate();
    t_both_strobes();
    t_wide_pair();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule